// File: doc/BRIEF.md
# Two-Wire Serial Slave Command Front End

This block lets a two-wire serial bus master load a 16-bit command word into a switch-control register block and fetch a 16-bit status image back out of it. It runs entirely in the system clock domain. The clock and data lines are each passed through a two-stage synchroniser and a short majority-free glitch filter, and every bus condition (START, repeated START, STOP, clock rising and falling edges) is derived from those filtered copies. The data line is open-drain: the block only ever asks to pull it low through an output enable, and a released line is read as high through an external pull-up.

A transfer begins with START and an address byte. The seven address bits are a fixed upper nibble of binary 1010 followed by three strap inputs, most significant bit first, and the eighth bit selects direction. On a match the block acknowledges. A write then takes exactly two acknowledged data bytes and presents them as one word on a single-cycle strobe. A read sends the status word, upper byte first, captured at the moment the address was acknowledged. A START or STOP at any point abandons the transfer in progress.

The write word leaves on a valid-only stream: there is no ready input, because the bus cannot be held off (clock stretching is absent), so the consumer must take the word in the cycle the strobe is high. The status input is a plain level that is sampled, not handshaken.

Top module: `i2c_cmd_slave`

## Requirements
- R1: While reset is asserted and after it is released with an idle bus, the data output enable is 0 and the write strobe is 0.
- R2: An address byte whose seven address bits equal 1010 followed by strap bits 2, 1, 0 (sent most significant bit first, the eighth bit 0 for write and 1 for read) is acknowledged by pulling the data line low during the ninth clock pulse.
- R3: An address byte that does not match gets no acknowledge, and the block leaves the data line released (data bytes that follow are not acknowledged and reads return 0xFF) and issues no write strobe until the next START.
- R4: After a matching write address, each of the two data bytes is acknowledged, and the block issues one write strobe whose word holds the first byte in bits 15:8 and the second in bits 7:0.
- R5: The write strobe is high for exactly one clock cycle per completed word, and the word output keeps its value until the next completed word.
- R6: In a write, any byte after the second is not acknowledged and produces no further strobe.
- R7: A STOP or repeated START before the second data byte's acknowledge has finished discards the partial word (no strobe), and a repeated START begins a fresh address phase that is handled normally.
- R8: After a matching read address, the block transmits the status word, bits 15:8 first, most significant bit first, using the status value sampled when the address acknowledge ends; later changes of the status input do not alter that transfer.
- R9: When the master does not acknowledge a read byte, the block stops transmitting and keeps the data line released (further clocked bytes read 0xFF) so that the master can issue STOP.
- R10: The block changes its data output enable to drive low only while the filtered clock line is low.
- R11: A pulse on the data line shorter than the filter length (3 system clocks by default) while the clock line is high is ignored: it creates no START or STOP and does not disturb the byte being received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all bus sampling is done on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (pull-up resolved) |
| strap_i | input | 3 | Address strap bits, placed in the three low address bits |
| sda_oe_o | output | 1 | When 1, the pad pulls the data line low; when 0 it is released |
| wr_valid_o | output | 1 | Single-cycle strobe: a complete command word is on wr_word_o |
| wr_word_o | output | 16 | Last completed command word, first received byte in the upper half |
| stat_word_i | input | 16 | Status image, sampled at the end of a read address acknowledge |

## Verification
A wrong bit counter or state at the byte engine shows within one byte at the ports: the acknowledge lands on the wrong clock pulse, so the master sees a NACK on a matching address or on a data byte, or a read byte arrives shifted. A broken address comparison or a filter that lets a short pulse through turns into a missing strobe or a spurious acknowledge in the same transaction. A fault in the word assembly or the snapshot point appears as a wrong strobe word or status readback at the end of the transfer, and a timing fault in the drive logic appears as the enable changing while the bus clock is high.

// File: rtl/i2c_cmd_slave_pkg.sv
package i2c_cmd_slave_pkg;
  localparam int BYTE_BITS = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_SKIP
  } bus_state_t;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    win_q;
  logic                   filt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      win_q  <= '1;
      filt_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
      win_q  <= {win_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      if (&win_q)
        filt_q <= 1'b1;
      else if (~|win_q)
        filt_q <= 1'b0;
    end
  end

  assign filt_o = filt_q;

  // R11
  filt_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> ($past(win_q) == '0 || $past(win_q) == '1));
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f_i,
  input  logic sda_f_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f_i;
      sda_q <= sda_f_i;
    end
  end

  always_comb begin
    start_o    = scl_q & scl_f_i & sda_q & ~sda_f_i;
    stop_o     = scl_q & scl_f_i & ~sda_q & sda_f_i;
    scl_rise_o = ~scl_q & scl_f_i;
    scl_fall_o = scl_q & ~scl_f_i;
  end
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_cmd_slave_pkg::*;
#(
  parameter logic [3:0] ADDR_HI    = 4'b1010,
  parameter int         WORD_BYTES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        scl_f_i,
  input  logic                        sda_f_i,
  input  logic                        start_i,
  input  logic                        stop_i,
  input  logic                        scl_rise_i,
  input  logic                        scl_fall_i,
  input  logic [2:0]                  strap_i,
  input  logic [WORD_BYTES*8-1:0]     stat_word_i,
  output logic                        sda_oe_o,
  output logic                        wr_valid_o,
  output logic [WORD_BYTES*8-1:0]     wr_word_o
);
  localparam int WORD_W = WORD_BYTES * BYTE_BITS;
  localparam int CNT_W  = $clog2(BYTE_BITS + 1);
  localparam int BC_W   = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BYTE_BITS);
  localparam logic [BC_W-1:0]  LAST_BYTE = BC_W'(WORD_BYTES - 1);

  bus_state_t          state_q;
  logic [CNT_W-1:0]    bit_q;
  logic [BC_W-1:0]     byte_q;
  logic [BYTE_BITS-1:0] addr_sh_q;
  logic [WORD_W-1:0]   rx_sh_q;
  logic [WORD_W-1:0]   tx_sh_q;
  logic                rw_q;
  logic                mack_q;
  logic                oe_q;
  logic                valid_q;
  logic [WORD_W-1:0]   word_q;
  logic                addr_hit;

  assign addr_hit = (addr_sh_q[BYTE_BITS-1:1] == {ADDR_HI, strap_i});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      bit_q     <= '0;
      byte_q    <= '0;
      addr_sh_q <= '0;
      rx_sh_q   <= '0;
      tx_sh_q   <= '0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      oe_q      <= 1'b0;
      valid_q   <= 1'b0;
      word_q    <= '0;
    end else begin
      valid_q <= 1'b0;
      if (start_i) begin
        state_q <= ST_ADDR;
        bit_q   <= '0;
        byte_q  <= '0;
        oe_q    <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else if (scl_rise_i) begin
        case (state_q)
          ST_ADDR: begin
            addr_sh_q <= {addr_sh_q[BYTE_BITS-2:0], sda_f_i};
            bit_q     <= bit_q + 1'b1;
          end
          ST_WDATA: begin
            rx_sh_q <= {rx_sh_q[WORD_W-2:0], sda_f_i};
            bit_q   <= bit_q + 1'b1;
          end
          ST_RDATA: bit_q <= bit_q + 1'b1;
          ST_RACK:  mack_q <= ~sda_f_i;
          default: ;
        endcase
      end else if (scl_fall_i) begin
        case (state_q)
          ST_ADDR: begin
            if (bit_q == LAST_BIT) begin
              if (addr_hit) begin
                state_q <= ST_AACK;
                rw_q    <= addr_sh_q[0];
                oe_q    <= 1'b1;
              end else begin
                state_q <= ST_SKIP;
              end
            end
          end
          ST_AACK: begin
            bit_q  <= '0;
            byte_q <= '0;
            if (rw_q) begin
              state_q <= ST_RDATA;
              tx_sh_q <= stat_word_i;
              oe_q    <= ~stat_word_i[WORD_W-1];
            end else begin
              state_q <= ST_WDATA;
              oe_q    <= 1'b0;
            end
          end
          ST_WDATA: begin
            if (bit_q == LAST_BIT) begin
              state_q <= ST_WACK;
              oe_q    <= 1'b1;
            end
          end
          ST_WACK: begin
            oe_q  <= 1'b0;
            bit_q <= '0;
            if (byte_q == LAST_BYTE) begin
              valid_q <= 1'b1;
              word_q  <= rx_sh_q;
              state_q <= ST_SKIP;
            end else begin
              byte_q  <= byte_q + 1'b1;
              state_q <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            tx_sh_q <= {tx_sh_q[WORD_W-2:0], 1'b0};
            if (bit_q == LAST_BIT) begin
              state_q <= ST_RACK;
              oe_q    <= 1'b0;
            end else begin
              oe_q <= ~tx_sh_q[WORD_W-2];
            end
          end
          ST_RACK: begin
            bit_q <= '0;
            if (mack_q && byte_q != LAST_BYTE) begin
              byte_q  <= byte_q + 1'b1;
              state_q <= ST_RDATA;
              oe_q    <= ~tx_sh_q[WORD_W-1];
            end else begin
              state_q <= ST_SKIP;
              oe_q    <= 1'b0;
            end
          end
          default: oe_q <= 1'b0;
        endcase
      end
    end
  end

  assign sda_oe_o   = oe_q;
  assign wr_valid_o = valid_q;
  assign wr_word_o  = word_q;

  // R10
  oe_change_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !scl_f_i);

  // R5
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // R7
  cond_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i || stop_i) |=> !oe_q);

  // R11
  event_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_i, stop_i, scl_rise_i, scl_fall_i}));
endmodule

// File: rtl/i2c_cmd_slave.sv
module i2c_cmd_slave #(
  parameter logic [3:0] ADDR_HI     = 4'b1010,
  parameter int         WORD_BYTES  = 2,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  input  logic [2:0]              strap_i,
  output logic                    sda_oe_o,
  output logic                    wr_valid_o,
  output logic [WORD_BYTES*8-1:0] wr_word_o,
  input  logic [WORD_BYTES*8-1:0] stat_word_i
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_lines;
  logic [N_LINES-1:0] filt_lines;
  logic start_w, stop_w, rise_w, fall_w;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    i2c_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_i (raw_lines[g]),
      .filt_o(filt_lines[g])
    );
  end

  i2c_cond_detect u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_f_i   (filt_lines[1]),
    .sda_f_i   (filt_lines[0]),
    .start_o   (start_w),
    .stop_o    (stop_w),
    .scl_rise_o(rise_w),
    .scl_fall_o(fall_w)
  );

  i2c_byte_engine #(
    .ADDR_HI   (ADDR_HI),
    .WORD_BYTES(WORD_BYTES)
  ) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_f_i    (filt_lines[1]),
    .sda_f_i    (filt_lines[0]),
    .start_i    (start_w),
    .stop_i     (stop_w),
    .scl_rise_i (rise_w),
    .scl_fall_i (fall_w),
    .strap_i    (strap_i),
    .stat_word_i(stat_word_i),
    .sda_oe_o   (sda_oe_o),
    .wr_valid_o (wr_valid_o),
    .wr_word_o  (wr_word_o)
  );
endmodule

// File: tb/i2c_cmd_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_cmd_slave_tb_top;
  localparam int Q = 10;
  localparam logic [2:0] STRAP = 3'b101;
  localparam int NVEC = 7;
  // {rd, addr7, data16}
  localparam logic [23:0] VEC [NVEC] = '{
    24'h55A53C, 24'h541234, 24'hD58001, 24'h950F0F,
    24'h55FF00, 24'hD57EC3, 24'h5D5555
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [15:0] stat = 16'h0000;
  logic sda_oe, wr_valid;
  logic [15:0] wr_word;
  logic sda_bus;

  int checks = 0;
  int fails = 0;
  int strobes = 0;
  int multi_hi = 0;
  int bad_change = 0;
  logic [15:0] last_word = 16'h0;
  logic prev_valid = 1'b0;
  logic prev_oe = 1'b0;
  bit done = 1'b0;

  assign sda_bus = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  i2c_cmd_slave dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_bus),
    .strap_i    (STRAP),
    .sda_oe_o   (sda_oe),
    .wr_valid_o (wr_valid),
    .wr_word_o  (wr_word),
    .stat_word_i(stat)
  );

  always @(negedge clk) begin
    if (wr_valid) begin
      strobes++;
      last_word = wr_word;
      if (prev_valid) multi_hi++;
    end
    if (rst_n && sda_oe != prev_oe && scl_m) bad_change++;
    prev_valid = wr_valid;
    prev_oe = sda_oe;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; waitc(Q);
    scl_m = 1'b1; waitc(Q);
    sda_m = 1'b0; waitc(Q);
    scl_m = 1'b0; waitc(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitc(Q);
    scl_m = 1'b1; waitc(Q);
    sda_m = 1'b1; waitc(2*Q);
  endtask

  task automatic clk_bit(input logic b, input bit glitch, output logic s);
    sda_m = b; waitc(Q);
    scl_m = 1'b1; waitc(Q);
    s = sda_bus;
    if (glitch) begin
      sda_m = ~b; waitc(1);
      sda_m = b;  waitc(Q-1);
    end else begin
      waitc(Q);
    end
    scl_m = 1'b0; waitc(Q);
  endtask

  task automatic write_byte(input logic [7:0] b, input int gidx, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], (i == gidx), s);
    clk_bit(1'b1, 1'b0, s);
    ack = ~s;
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, 1'b0, s);
      b[i] = s;
    end
    clk_bit(~mack, 1'b0, s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    logic ack, a1, a2, a3;
    logic [7:0] b1, b2;
    int c0;

    // R1: reset state
    waitc(3);
    check(sda_oe == 1'b0 && wr_valid == 1'b0, "R1 in reset", {sda_oe, wr_valid}, 0);
    rst_n = 1'b1;
    waitc(20);
    check(sda_oe == 1'b0 && wr_valid == 1'b0, "R1 after reset", {sda_oe, wr_valid}, 0);

    for (int k = 0; k < NVEC; k++) begin
      logic rd;
      logic [6:0] addr;
      logic [15:0] data;
      logic hit;
      rd   = VEC[k][23];
      addr = VEC[k][22:16];
      data = VEC[k][15:0];
      hit  = (addr[6:3] == 4'b1010) && (addr[2:0] == STRAP);
      c0 = strobes;
      if (rd) stat = data;
      bus_start();
      write_byte({addr, rd}, -1, ack);
      check(ack == hit, hit ? "R2 address ack" : "R3 address nack", ack, hit);
      if (!rd) begin
        write_byte(data[15:8], -1, a1);
        write_byte(data[7:0], -1, a2);
        bus_stop();
        if (hit) begin
          check(a1 && a2, "R4 data acks", {a1, a2}, 2'b11);
          check(strobes == c0 + 1, "R4 one strobe", strobes, c0 + 1);
          check(last_word == data, "R4 word order", last_word, data);
        end else begin
          check(!a1 && !a2, "R3 data not acked", {a1, a2}, 0);
          check(strobes == c0, "R3 no strobe", strobes, c0);
        end
      end else begin
        if (hit) begin
          stat = ~data; // R8 snapshot: must not affect this read
          read_byte(1'b1, b1);
          read_byte(1'b0, b2);
          bus_stop();
          check({b1, b2} == data, "R8 status readback", {b1, b2}, data);
        end else begin
          read_byte(1'b0, b1);
          bus_stop();
          check(b1 == 8'hFF, "R3 released on read", b1, 8'hFF);
        end
      end
      waitc(2*Q);
    end

    // R5: word holds after strobe
    check(wr_word == 16'hFF00, "R5 word held", wr_word, 16'hFF00);

    // R6: third write byte not acked
    c0 = strobes;
    bus_start();
    write_byte({4'b1010, STRAP, 1'b0}, -1, ack);
    write_byte(8'h3C, -1, a1);
    write_byte(8'h96, -1, a2);
    write_byte(8'h77, -1, a3);
    bus_stop();
    check(a1 && a2 && !a3, "R6 third byte nack", {a1, a2, a3}, 3'b110);
    check(strobes == c0 + 1 && last_word == 16'h3C96, "R6 single strobe",
          {strobes[15:0], last_word}, {16'(c0 + 1), 16'h3C96});

    // R7: STOP after one byte discards
    c0 = strobes;
    bus_start();
    write_byte({4'b1010, STRAP, 1'b0}, -1, ack);
    write_byte(8'h11, -1, a1);
    bus_stop();
    check(strobes == c0, "R7 stop discards", strobes, c0);

    // R7: repeated START after one byte, then fresh write
    bus_start();
    write_byte({4'b1010, STRAP, 1'b0}, -1, ack);
    write_byte(8'h22, -1, a1);
    bus_start();
    write_byte({4'b1010, STRAP, 1'b0}, -1, ack);
    check(ack == 1'b1, "R7 re-address ack", ack, 1);
    write_byte(8'hC3, -1, a1);
    write_byte(8'h5A, -1, a2);
    bus_stop();
    check(strobes == c0 + 1 && last_word == 16'hC35A, "R7 fresh word",
          {strobes[15:0], last_word}, {16'(c0 + 1), 16'hC35A});

    // R9: master NACK after first read byte
    stat = 16'hB7E1;
    bus_start();
    write_byte({4'b1010, STRAP, 1'b1}, -1, ack);
    read_byte(1'b0, b1);
    read_byte(1'b0, b2);
    bus_stop();
    check(b1 == 8'hB7, "R9 first byte", b1, 8'hB7);
    check(b2 == 8'hFF, "R9 released after nack", b2, 8'hFF);

    // R11: short pulses while clock high are ignored
    c0 = strobes;
    bus_start();
    write_byte({4'b1010, STRAP, 1'b0}, -1, ack);
    write_byte(8'hF0, 6, a1);
    write_byte(8'h0F, 6, a2);
    bus_stop();
    check(a1 && a2, "R11 acks through glitch", {a1, a2}, 2'b11);
    check(strobes == c0 + 1 && last_word == 16'hF00F, "R11 word intact",
          {strobes[15:0], last_word}, {16'(c0 + 1), 16'hF00F});

    check(multi_hi == 0, "R5 strobe width", multi_hi, 0);
    check(bad_change == 0, "R10 drive change while clock high", bad_change, 0);
    report();
  end
endmodule